// File: doc/BRIEF.md
# OLED Controller Init Sequencer

This block brings a monochrome OLED panel controller out of reset and programs it. When a start request arrives while the block is idle, it drives a reset pulse to the panel, waits, and then sends a fixed list of configuration bytes over a byte-wide transmit port with a valid/ready handshake. Every byte sent is flagged as a command byte. The serial or I2C link that carries the bytes is outside the block.

The configuration arrives on input ports and is captured at the start request. Most command bytes are constants. Their operands are built from the captured settings: some are passed straight through, some are derived (height minus one, divider minus one), one bit is inverted, one command is sent only under a condition, and a lookup table of parameter length is optional. A one-cycle done pulse marks the end of the list.

Top module: `oled_init_seq`

## Requirements
- R1: A start request in idle raises `panel_rst` for exactly RST_CYCLES cycles. It then stays low for RST_CYCLES more cycles before the first byte is offered, and no byte is offered while `panel_rst` is high.
- R2: The first bytes, in order, are 0x81 then the contrast value; 0xA0 with the segment-remap flag in bit 0; 0xC0 with the scan-flip flag in bit 3; 0xA8 then height minus 1; 0xD3 then the display offset.
- R3: Next comes 0xD5 with an operand whose bits 3:0 are the low nibble of (divider minus 1) and whose bits 7:4 are the oscillator frequency code.
- R4: 0xD8 and its operand follow only when area colour or low power is enabled. The operand is 0x1E for area colour, ORed with 0x05 for low power. With both disabled, neither byte is sent.
- R5: Next comes 0xD9 with precharge phase 1 in bits 3:0 and phase 2 in bits 7:4.
- R6: Next comes 0xDA. Its operand has bit 1 always set, bit 4 equal to the inverse of the sequential-COM flag, bit 5 equal to the left/right remap flag, and all other bits zero.
- R7: Next comes 0xDB then the VCOMH value. Then comes 0x8D with an operand of 0x10, plus 0x04 when the charge pump is required.
- R8: When the table enable is set, 0x91 follows, then the LUT_N table entries as separate bytes: entry 0 is `cfg_lut[7:0]`, entry i is `cfg_lut[8i+7:8i]`. Entries are sent unchanged. With the enable clear, none of these bytes is sent.
- R9: The last two bytes are 0x20, then 0x02 for page mode or 0x00 for horizontal mode.
- R10: `tx_cmd` is 1 on every offered byte. An offered byte keeps `tx_valid` high and `tx_data` unchanged until a cycle in which `tx_ready` is high.
- R11: `done` is high for exactly one cycle, the cycle after the final byte is accepted. It is raised once per sequence.
- R12: Start requests while a sequence runs are ignored. Configuration changes after the start request do not change the bytes of the running sequence.
- R13: Synchronous reset `rst` returns the block to idle, with `panel_rst`, `tx_valid` and `done` low, even in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin the power-up sequence (used only in idle) |
| cfg_contrast | input | 8 | Contrast value |
| cfg_seg_remap | input | 1 | Segment remap flag |
| cfg_com_flip | input | 1 | COM scan direction flag |
| cfg_height | input | 8 | Panel height in rows |
| cfg_disp_offset | input | 8 | Display offset |
| cfg_clk_div | input | 5 | Display clock divider, 1 to 16 |
| cfg_osc_freq | input | 4 | Oscillator frequency code |
| cfg_pre_p1 | input | 4 | Precharge phase 1 |
| cfg_pre_p2 | input | 4 | Precharge phase 2 |
| cfg_com_seq | input | 1 | Sequential COM layout flag |
| cfg_com_lr | input | 1 | COM left/right remap flag |
| cfg_vcomh | input | 8 | VCOMH level |
| cfg_pump_req | input | 1 | Charge pump required |
| cfg_area_color | input | 1 | Area colour enable |
| cfg_low_power | input | 1 | Low power enable |
| cfg_lut_en | input | 1 | Send the lookup table |
| cfg_lut | input | 8*LUT_N | Lookup table entries, entry 0 in the low byte |
| cfg_page_mode | input | 1 | 1 selects page addressing, 0 horizontal |
| panel_rst | output | 1 | Panel reset drive, active high |
| tx_valid | output | 1 | Byte offered |
| tx_cmd | output | 1 | Command/data flag, 1 for a command byte |
| tx_data | output | 8 | Byte value |
| tx_ready | input | 1 | Downstream accepts the byte |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest cases to reach are those in which the inputs move while a sequence runs. A second start request and new configuration values can arrive during the reset wait and again during byte transfer, while the downstream ready stalls at random. The bench drives start pulses in both phases and rewrites every configuration port just after the start request. It runs with ready always high and with sparse random ready. Every byte is compared against a list built from the configuration captured at start, and the bench checks that no second reset pulse or extra byte appears after done.

// File: rtl/oled_init_seq.sv
module oled_init_seq #(
  parameter int RST_CYCLES = 400,
  parameter int LUT_N      = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [7:0]         cfg_contrast,
  input  logic               cfg_seg_remap,
  input  logic               cfg_com_flip,
  input  logic [7:0]         cfg_height,
  input  logic [7:0]         cfg_disp_offset,
  input  logic [4:0]         cfg_clk_div,
  input  logic [3:0]         cfg_osc_freq,
  input  logic [3:0]         cfg_pre_p1,
  input  logic [3:0]         cfg_pre_p2,
  input  logic               cfg_com_seq,
  input  logic               cfg_com_lr,
  input  logic [7:0]         cfg_vcomh,
  input  logic               cfg_pump_req,
  input  logic               cfg_area_color,
  input  logic               cfg_low_power,
  input  logic               cfg_lut_en,
  input  logic [8*LUT_N-1:0] cfg_lut,
  input  logic               cfg_page_mode,
  output logic               panel_rst,
  output logic               tx_valid,
  output logic               tx_cmd,
  output logic [7:0]         tx_data,
  input  logic               tx_ready,
  output logic               done
);

  localparam int CW        = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam int LUT_BASE  = 21;
  localparam int MODE_SLOT = LUT_BASE + LUT_N;
  localparam int NSLOT     = MODE_SLOT + 2;
  localparam int SW        = $clog2(NSLOT);
  localparam int LIW       = (LUT_N > 1) ? $clog2(LUT_N) : 1;

  typedef enum logic [1:0] {S_IDLE, S_RST_ON, S_RST_WAIT, S_SEND} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [SW-1:0] slot;
  logic [7:0]    slot_byte;
  logic          slot_skip;
  logic [LIW-1:0] lut_idx;
  logic          take;

  logic [7:0] b_contrast, b_remap, b_scan, b_mux, b_offs, b_clk;
  logic [7:0] b_area, b_pre, b_pins, b_vcomh, b_pump, b_mode;
  logic       area_on, lut_on;
  logic [7:0] lut_r [LUT_N];

  assign take = (state == S_IDLE) && start;

  always_ff @(posedge clk) begin
    if (take) begin
      b_contrast <= cfg_contrast;
      b_remap    <= {7'b1010000, cfg_seg_remap};
      b_scan     <= {4'hC, cfg_com_flip, 3'b000};
      b_mux      <= cfg_height - 8'd1;
      b_offs     <= cfg_disp_offset;
      b_clk      <= {cfg_osc_freq, 4'(cfg_clk_div - 5'd1)};
      area_on    <= cfg_area_color | cfg_low_power;
      b_area     <= (cfg_area_color ? 8'h1E : 8'h00) | (cfg_low_power ? 8'h05 : 8'h00);
      b_pre      <= {cfg_pre_p2, cfg_pre_p1};
      b_pins     <= {2'b00, cfg_com_lr, ~cfg_com_seq, 4'b0010};
      b_vcomh    <= cfg_vcomh;
      b_pump     <= {5'b00010, cfg_pump_req, 2'b00};
      lut_on     <= cfg_lut_en;
      b_mode     <= cfg_page_mode ? 8'h02 : 8'h00;
    end
  end

  for (genvar g = 0; g < LUT_N; g++) begin : g_lut
    always_ff @(posedge clk) begin
      if (take) lut_r[g] <= cfg_lut[8*g +: 8];
    end
  end

  assign lut_idx = LIW'(slot - SW'(LUT_BASE));

  always_comb begin
    slot_byte = 8'h00;
    slot_skip = 1'b0;
    if (slot >= SW'(LUT_BASE) && slot < SW'(MODE_SLOT)) begin
      slot_byte = lut_r[lut_idx];
      slot_skip = !lut_on;
    end else if (slot == SW'(MODE_SLOT)) begin
      slot_byte = 8'h20;
    end else if (slot == SW'(MODE_SLOT + 1)) begin
      slot_byte = b_mode;
    end else begin
      case (slot)
        SW'(0):  slot_byte = 8'h81;
        SW'(1):  slot_byte = b_contrast;
        SW'(2):  slot_byte = b_remap;
        SW'(3):  slot_byte = b_scan;
        SW'(4):  slot_byte = 8'hA8;
        SW'(5):  slot_byte = b_mux;
        SW'(6):  slot_byte = 8'hD3;
        SW'(7):  slot_byte = b_offs;
        SW'(8):  slot_byte = 8'hD5;
        SW'(9):  slot_byte = b_clk;
        SW'(10): begin slot_byte = 8'hD8;  slot_skip = !area_on; end
        SW'(11): begin slot_byte = b_area; slot_skip = !area_on; end
        SW'(12): slot_byte = 8'hD9;
        SW'(13): slot_byte = b_pre;
        SW'(14): slot_byte = 8'hDA;
        SW'(15): slot_byte = b_pins;
        SW'(16): slot_byte = 8'hDB;
        SW'(17): slot_byte = b_vcomh;
        SW'(18): slot_byte = 8'h8D;
        SW'(19): slot_byte = b_pump;
        SW'(20): begin slot_byte = 8'h91; slot_skip = !lut_on; end
        default: slot_byte = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cnt   <= '0;
      slot  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state <= S_RST_ON;
          cnt   <= '0;
        end
        S_RST_ON: if (cnt == CW'(RST_CYCLES - 1)) begin
          state <= S_RST_WAIT;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        S_RST_WAIT: if (cnt == CW'(RST_CYCLES - 1)) begin
          state <= S_SEND;
          cnt   <= '0;
          slot  <= '0;
        end else cnt <= cnt + 1'b1;
        S_SEND: if (slot_skip || tx_ready) begin
          if (slot == SW'(NSLOT - 1)) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else slot <= slot + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign panel_rst = (state == S_RST_ON);
  assign tx_valid  = (state == S_SEND) && !slot_skip;
  assign tx_cmd    = 1'b1;
  assign tx_data   = slot_byte;

endmodule

// File: rtl/oled_init_seq_chk.sv
module oled_init_seq_chk #(
  parameter int RST_CYCLES = 400
) (
  input logic       clk,
  input logic       rst,
  input logic       panel_rst,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       done
);

  logic [31:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst) hi_run <= '0;
    else     hi_run <= panel_rst ? hi_run + 32'd1 : 32'd0;
  end

  p_rst_width_r1: assert property (@(posedge clk) disable iff (rst)
    ($fell(panel_rst) && !$past(rst)) |-> hi_run == 32'(RST_CYCLES));

  p_no_byte_in_rst_r1: assert property (@(posedge clk) disable iff (rst)
    panel_rst |-> !tx_valid);

  p_hold_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_after_accept_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(tx_valid && tx_ready));

  p_reset_idle_r13: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!panel_rst && !tx_valid && !done));

endmodule

bind oled_init_seq oled_init_seq_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .panel_rst(panel_rst), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .done(done)
);

// File: tb/tb_oled_init_seq.sv
module tb_oled_init_seq;
  localparam int RC = 20;
  localparam int LN = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] cfg_contrast, cfg_height, cfg_disp_offset, cfg_vcomh;
  logic cfg_seg_remap, cfg_com_flip, cfg_com_seq, cfg_com_lr;
  logic cfg_pump_req, cfg_area_color, cfg_low_power, cfg_lut_en, cfg_page_mode;
  logic [4:0] cfg_clk_div;
  logic [3:0] cfg_osc_freq, cfg_pre_p1, cfg_pre_p2;
  logic [8*LN-1:0] cfg_lut;
  logic panel_rst, tx_valid, tx_cmd, done;
  logic [7:0] tx_data;
  logic tx_ready = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int rdy_mode = 0;
  logic [7:0] exp_b [64];
  string exp_tag [64];
  int exp_n;
  logic [7:0] got [64];

  always #5 clk = ~clk;

  oled_init_seq #(.RST_CYCLES(RC), .LUT_N(LN)) dut (
    .clk(clk), .rst(rst), .start(start),
    .cfg_contrast(cfg_contrast), .cfg_seg_remap(cfg_seg_remap), .cfg_com_flip(cfg_com_flip),
    .cfg_height(cfg_height), .cfg_disp_offset(cfg_disp_offset), .cfg_clk_div(cfg_clk_div),
    .cfg_osc_freq(cfg_osc_freq), .cfg_pre_p1(cfg_pre_p1), .cfg_pre_p2(cfg_pre_p2),
    .cfg_com_seq(cfg_com_seq), .cfg_com_lr(cfg_com_lr), .cfg_vcomh(cfg_vcomh),
    .cfg_pump_req(cfg_pump_req), .cfg_area_color(cfg_area_color), .cfg_low_power(cfg_low_power),
    .cfg_lut_en(cfg_lut_en), .cfg_lut(cfg_lut), .cfg_page_mode(cfg_page_mode),
    .panel_rst(panel_rst), .tx_valid(tx_valid), .tx_cmd(tx_cmd), .tx_data(tx_data),
    .tx_ready(tx_ready), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, what, act, act, expv, expv);
    end
  endtask

  task automatic push(input logic [7:0] b, input string tag);
    exp_b[exp_n] = b;
    exp_tag[exp_n] = tag;
    exp_n++;
  endtask

  task automatic build_expected();
    logic [4:0] dm1;
    exp_n = 0;
    dm1 = cfg_clk_div - 5'd1;
    push(8'h81, "R2"); push(cfg_contrast, "R2");
    push(8'hA0 | {7'd0, cfg_seg_remap}, "R2");
    push(8'hC0 | (cfg_com_flip ? 8'h08 : 8'h00), "R2");
    push(8'hA8, "R2"); push(cfg_height - 8'd1, "R2");
    push(8'hD3, "R2"); push(cfg_disp_offset, "R2");
    push(8'hD5, "R3"); push({cfg_osc_freq, dm1[3:0]}, "R3");
    if (cfg_area_color || cfg_low_power) begin
      push(8'hD8, "R4");
      push((cfg_area_color ? 8'h1E : 8'h00) | (cfg_low_power ? 8'h05 : 8'h00), "R4");
    end
    push(8'hD9, "R5"); push({cfg_pre_p2, cfg_pre_p1}, "R5");
    push(8'hDA, "R6");
    push(8'h02 | (cfg_com_seq ? 8'h00 : 8'h10) | (cfg_com_lr ? 8'h20 : 8'h00), "R6");
    push(8'hDB, "R7"); push(cfg_vcomh, "R7");
    push(8'h8D, "R7"); push(8'h10 | (cfg_pump_req ? 8'h04 : 8'h00), "R7");
    if (cfg_lut_en) begin
      push(8'h91, "R8");
      for (int i = 0; i < LN; i++) push(cfg_lut[8*i +: 8], "R8");
    end
    push(8'h20, "R9"); push(cfg_page_mode ? 8'h02 : 8'h00, "R9");
  endtask

  task automatic randomize_cfg();
    cfg_contrast = 8'($urandom); cfg_seg_remap = 1'($urandom); cfg_com_flip = 1'($urandom);
    cfg_height = 8'($urandom_range(1, 64)); cfg_disp_offset = 8'($urandom_range(0, 63));
    cfg_clk_div = 5'($urandom_range(1, 16)); cfg_osc_freq = 4'($urandom);
    cfg_pre_p1 = 4'($urandom); cfg_pre_p2 = 4'($urandom);
    cfg_com_seq = 1'($urandom); cfg_com_lr = 1'($urandom); cfg_vcomh = 8'($urandom);
    cfg_pump_req = 1'($urandom); cfg_area_color = 1'($urandom); cfg_low_power = 1'($urandom);
    cfg_lut_en = 1'($urandom); cfg_page_mode = 1'($urandom);
    for (int i = 0; i < LN; i++) cfg_lut[8*i +: 8] = 8'($urandom_range(31, 63));
  endtask

  function automatic logic pick_ready();
    case (rdy_mode)
      0: return 1'b1;
      1: return ($urandom_range(0, 3) != 0);
      default: return ($urandom_range(0, 3) == 0);
    endcase
  endfunction

  task automatic run_seq(input bit perturb);
    int hi = 0, lo = 0, nb = 0, done_cnt = 0, done_iter = -1, last_hs = -100;
    bit seen_valid = 0, cmd_ok = 1, prev_pend = 0, post_ok = 1;
    logic [7:0] prev_data = 8'h00;
    build_expected();
    @(negedge clk); start = 1'b1;
    for (int it = 0; it < 4000; it++) begin
      @(negedge clk);
      start = perturb && (it == 30 || it == 60);
      if (perturb && it == 5) randomize_cfg();
      tx_ready = pick_ready();
      #1;
      if (prev_pend) begin
        chk(tx_valid === 1'b1, "R10", "valid held while stalled", int'(tx_valid), 1);
        chk(tx_data === prev_data, "R10", "data held while stalled", int'(tx_data), int'(prev_data));
      end
      if (panel_rst) hi++;
      else if (hi > 0 && !seen_valid && !tx_valid) lo++;
      if (tx_valid) begin
        seen_valid = 1;
        if (tx_cmd !== 1'b1) cmd_ok = 0;
      end
      if (done_iter >= 0 && (tx_valid || panel_rst)) post_ok = 0;
      if (tx_valid && tx_ready) begin
        if (nb < 64) got[nb] = tx_data;
        nb++;
        last_hs = it;
      end
      prev_pend = tx_valid && !tx_ready;
      prev_data = tx_data;
      if (done === 1'b1) begin
        done_cnt++;
        if (done_cnt == 1) begin
          chk(last_hs == it - 1, "R11", "done one cycle after final accept", it - last_hs, 1);
          done_iter = it;
        end
      end
      if (done_iter >= 0 && it >= done_iter + 10) break;
    end
    tx_ready = 1'b0;
    chk(done_cnt == 1, "R11", "done pulse count", done_cnt, 1);
    chk(hi == RC, "R1", "reset high cycles", hi, RC);
    chk(lo == RC, "R1", "reset release gap", lo, RC);
    chk(nb == exp_n, "R8", "byte count", nb, exp_n);
    chk(cmd_ok, "R10", "command flag on every byte", int'(cmd_ok), 1);
    if (perturb) begin
      chk(hi == RC, "R12", "no restart from start during run", hi, RC);
      chk(post_ok, "R12", "quiet after done", int'(post_ok), 1);
    end
    for (int i = 0; i < exp_n && i < nb; i++)
      chk(got[i] === exp_b[i], exp_tag[i], $sformatf("byte %0d", i), int'(got[i]), int'(exp_b[i]));
  endtask

  task automatic reset_midway();
    randomize_cfg();
    tx_ready = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (RC + RC + 3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1;
    chk(panel_rst === 1'b0, "R13", "panel_rst after reset", int'(panel_rst), 0);
    chk(tx_valid === 1'b0, "R13", "tx_valid after reset", int'(tx_valid), 0);
    chk(done === 1'b0, "R13", "done after reset", int'(done), 0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); #1;
      chk(!tx_valid && !panel_rst && !done, "R13", "idle stays idle", int'(tx_valid), 0);
    end
    tx_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    randomize_cfg();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!panel_rst && !tx_valid && !done, "R13", "outputs idle after power-on reset",
        int'({panel_rst, tx_valid, done}), 0);

    cfg_area_color = 0; cfg_low_power = 0; cfg_lut_en = 0;
    cfg_clk_div = 5'd1; cfg_height = 8'd1; cfg_com_seq = 1; cfg_com_lr = 0; cfg_pump_req = 0;
    cfg_page_mode = 0; rdy_mode = 0;
    run_seq(0);

    randomize_cfg();
    cfg_area_color = 1; cfg_low_power = 1; cfg_lut_en = 1; cfg_clk_div = 5'd16;
    cfg_height = 8'd64; cfg_com_seq = 0; cfg_com_lr = 1; cfg_pump_req = 1; cfg_page_mode = 1;
    cfg_lut = {8'd63, 8'd31, 8'd63, 8'd31};
    rdy_mode = 2;
    run_seq(0);

    randomize_cfg();
    cfg_area_color = 0; cfg_low_power = 1;
    rdy_mode = 1;
    run_seq(1);

    reset_midway();
    randomize_cfg();
    rdy_mode = 0;
    run_seq(0);

    for (int r = 0; r < 10; r++) begin
      randomize_cfg();
      rdy_mode = r % 3;
      run_seq(r % 2 == 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule